// File: doc/BRIEF.md
# Privilege-Aware Interrupt Selector

This block decides, every clock, whether a hart should take an interrupt and which one. Each source has a pending bit, an enable bit and a delegation bit. A source whose delegation bit is clear is handled at machine level. A source whose delegation bit is set is handled at supervisor level. A source may compete only while its handling level accepts interrupts, given the hart's current privilege level and the two global enable bits. Among the sources that remain, the one with the lowest index wins.

The result goes through one register stage with a synchronous active-low reset. `take_irq` and `irq_cause` therefore show the decision for the inputs present at the previous rising clock edge. Trap entry and the storage of the control registers belong to the surrounding core.

Top module: `irq_select`

## Requirements
- R1: A source is a candidate only when both its bit in `pend_vec` and its bit in `en_vec` are 1. A source with either bit at 0 is never chosen.
- R2: Machine-level handling is open when `cur_priv` is below machine (values 0, 1 or 2), or when `cur_priv` is 3 and `m_gie` is 1. It is closed when `cur_priv` is 3 and `m_gie` is 0.
- R3: Supervisor-level handling is open when `cur_priv` is 0. When `cur_priv` is supervisor, it is open only if `s_gie` is 1. It is always closed when `cur_priv` is 3.
- R4: A candidate whose `deleg_vec` bit is 0 survives only while machine-level handling is open.
- R5: A candidate whose `deleg_vec` bit is 1 survives only while supervisor-level handling is open.
- R6: When at least one source survives, `take_irq` is 1 and `irq_cause` is the index of the lowest-numbered survivor.
- R7: When no source survives, `take_irq` is 0 and `irq_cause` is 0.
- R8: `cur_priv` encodes user as 0, supervisor as 1 and machine as 3. The reserved value 2 behaves exactly like supervisor.
- R9: The outputs show the decision for the inputs sampled at the previous rising edge of `clk`. A rising edge with `rst_n` at 0 clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_vec | input | NUM_SRC | Pending bit per source |
| en_vec | input | NUM_SRC | Enable bit per source |
| deleg_vec | input | NUM_SRC | 1 = source handled at supervisor level |
| cur_priv | input | 2 | Current privilege level (0 U, 1 S, 3 M, 2 reserved) |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take_irq | output | 1 | An interrupt is to be taken |
| irq_cause | output | $clog2(NUM_SRC) | Index of the chosen source |

## Verification
The bench targets the cases that separate this selector from a plain priority encoder:
- A delegated source at machine privilege must be dropped. A design that ignored delegation would take it.
- At supervisor privilege with `s_gie` low, a lower-numbered delegated source must lose to a higher-numbered machine-level source. A design that encoded before masking would report the wrong cause.
- The reserved privilege value must gate like supervisor. A design that used plain compares would close the supervisor level there, or would open it without checking `s_gie`.
- A source pending without its enable bit, a single source at the top index and the all-zero vectors check the edges of the lowest-bit search and the cause reported when nothing is taken.

// File: rtl/irq_select_pkg.sv
// Shared types for the interrupt selector.
// Assumes a two-bit privilege code; the value 2 is reserved.
package irq_select_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;
endpackage

// File: rtl/irq_level_gate.sv
// Works out whether the machine and supervisor handling levels accept
// interrupts at the current privilege level.
// Assumes: the reserved privilege code is folded onto supervisor.
module irq_level_gate
    import irq_select_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       m_gie,
    input  logic       s_gie,
    output logic       m_open,
    output logic       s_open
);
    priv_e eff_priv;

    // Fold the reserved code onto supervisor.
    always_comb begin
        if (cur_priv == PRIV_RSVD) eff_priv = PRIV_SUPER;
        else                       eff_priv = priv_e'(cur_priv);
    end

    // Per-level global enable.
    always_comb begin
        m_open = (eff_priv != PRIV_MACH) || m_gie;
        case (eff_priv)
            PRIV_USER:  s_open = 1'b1;
            PRIV_SUPER: s_open = s_gie;
            default:    s_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_mask_apply.sv
// Keeps each enabled pending source only when the level that handles it
// (chosen by its delegation bit) is open.
// Assumes: all vectors share the same bit order.
module irq_mask_apply #(
    parameter int NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] pend_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic [NUM_SRC-1:0] deleg_vec,
    input  logic               m_open,
    input  logic               s_open,
    output logic [NUM_SRC-1:0] surv_vec
);
    logic [NUM_SRC-1:0] cand_vec;

    // Candidates, then per-target gating.
    always_comb begin
        cand_vec = pend_vec & en_vec;
        surv_vec = (cand_vec & ~deleg_vec & {NUM_SRC{m_open}})
                 | (cand_vec &  deleg_vec & {NUM_SRC{s_open}});
    end
endmodule

// File: rtl/irq_lowest_pick.sv
// Finds the lowest set bit of the survivor vector and reports its index.
// Assumes: NUM_SRC >= 2. The index is 0 when no bit is set.
module irq_lowest_pick #(
    parameter int NUM_SRC = 16,
    localparam int CW     = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] surv_vec,
    output logic               any_hit,
    output logic [CW-1:0]      hit_idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (surv_vec[i]) hit_idx = CW'(i);
        end
        any_hit = |surv_vec;
    end

    // R6: the reported index points at a set bit.
    always_comb begin
        if (any_hit) a_idx_is_set_r6: assert (surv_vec[hit_idx]);
    end
endmodule

// File: rtl/irq_select.sv
// Top of the interrupt selector: level gating, per-source masking and a
// lowest-index pick, with an optional output register.
// Assumes: REG_OUT = 1 (the default) gives a one-cycle latency. REG_OUT = 0
// gives a purely combinational path, and clk and rst_n are then unused.
module irq_select #(
    parameter int NUM_SRC = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int CW     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic [NUM_SRC-1:0] deleg_vec,
    input  logic [1:0]         cur_priv,
    input  logic               m_gie,
    input  logic               s_gie,
    output logic               take_irq,
    output logic [CW-1:0]      irq_cause
);
    logic               m_open;
    logic               s_open;
    logic [NUM_SRC-1:0] surv_vec;
    logic               any_hit;
    logic [CW-1:0]      hit_idx;

    irq_level_gate u_gate (
        .cur_priv (cur_priv),
        .m_gie    (m_gie),
        .s_gie    (s_gie),
        .m_open   (m_open),
        .s_open   (s_open)
    );

    irq_mask_apply #(.NUM_SRC(NUM_SRC)) u_mask (
        .pend_vec  (pend_vec),
        .en_vec    (en_vec),
        .deleg_vec (deleg_vec),
        .m_open    (m_open),
        .s_open    (s_open),
        .surv_vec  (surv_vec)
    );

    irq_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .surv_vec (surv_vec),
        .any_hit  (any_hit),
        .hit_idx  (hit_idx)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Output register with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    take_irq  <= 1'b0;
                    irq_cause <= '0;
                end else begin
                    take_irq  <= any_hit;
                    irq_cause <= hit_idx;
                end
            end

            p_cause_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !take_irq |-> irq_cause == '0);
            p_m_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_priv == 2'd3 && !m_gie) |=> !take_irq);
            p_no_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
                ((pend_vec & en_vec) == '0) |=> !take_irq);
            p_cause_was_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
                take_irq |-> ((($past(pend_vec & en_vec)) >> irq_cause) & NUM_SRC'(1)) != '0);
        end else begin : g_comb
            assign take_irq  = any_hit;
            assign irq_cause = hit_idx;
        end
    endgenerate
endmodule

// File: tb/test_irq_select.sv
module test_irq_select;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int CW = $clog2(N);

    typedef struct packed {
        logic [15:0] p;
        logic [15:0] e;
        logic [15:0] d;
        logic [1:0]  pr;
        logic        mie;
        logic        sie;
        logic        tk;
        logic [3:0]  cause;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{16'h0000, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  8'd7}, // R7 nothing pending
        '{16'hFFFF, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  8'd1}, // R1 nothing enabled
        '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd7,  8'd2}, // R2 M open
        '{16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0,  8'd2}, // R2 M closed
        '{16'h0080, 16'hFFFF, 16'h0080, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  8'd5}, // R5 delegated at M
        '{16'h0080, 16'hFFFF, 16'h0080, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  8'd3}, // R3 S closed
        '{16'h0080, 16'hFFFF, 16'h0080, 2'd1, 1'b0, 1'b1, 1'b1, 4'd7,  8'd3}, // R3 S open
        '{16'h0080, 16'hFFFF, 16'h0080, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7,  8'd3}, // R3 user always
        '{16'h0022, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 4'd5,  8'd4}, // R4 mask before pick
        '{16'h0022, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1,  8'd6}, // R6 lowest wins
        '{16'h0008, 16'hFFFF, 16'h0008, 2'd2, 1'b1, 1'b0, 1'b0, 4'd0,  8'd8}, // R8 reserved, S closed
        '{16'h0008, 16'hFFFF, 16'h0008, 2'd2, 1'b0, 1'b1, 1'b1, 4'd3,  8'd8}, // R8 reserved, S open
        '{16'h0010, 16'hFFFF, 16'h0000, 2'd2, 1'b0, 1'b0, 1'b1, 4'd4,  8'd8}, // R8 reserved below M
        '{16'h8000, 16'h8000, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd15, 8'd6}, // R6 top index
        '{16'hFFFF, 16'hFFFE, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd1,  8'd1}, // R1 bit 0 not enabled
        '{16'h8001, 16'hFFFF, 16'h0001, 2'd3, 1'b1, 1'b1, 1'b1, 4'd15, 8'd5}  // R5 delegated bit 0 dropped
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend_vec = '0;
    logic [N-1:0]  en_vec = '0;
    logic [N-1:0]  deleg_vec = '0;
    logic [1:0]    cur_priv = 2'd0;
    logic          m_gie = 1'b0;
    logic          s_gie = 1'b0;
    logic          take_irq;
    logic [CW-1:0] irq_cause;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_select #(.NUM_SRC(N)) i_irq_select (
        .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .en_vec(en_vec),
        .deleg_vec(deleg_vec), .cur_priv(cur_priv), .m_gie(m_gie), .s_gie(s_gie),
        .take_irq(take_irq), .irq_cause(irq_cause)
    );

    // Reference model written from the requirements, scanning upward.
    function automatic void ref_model(input logic [N-1:0] p, input logic [N-1:0] e,
                                      input logic [N-1:0] d, input logic [1:0] pr,
                                      input logic mie, input logic sie,
                                      output logic tk, output logic [CW-1:0] c);
        logic m_ok;
        logic s_ok;
        m_ok = (pr != 2'd3) || mie;
        s_ok = (pr == 2'd0) || ((pr == 2'd1 || pr == 2'd2) && sie);
        tk = 1'b0;
        c  = '0;
        for (int i = 0; i < N; i++) begin
            if (!tk && p[i] && e[i] && (d[i] ? s_ok : m_ok)) begin
                tk = 1'b1;
                c  = CW'(i);
            end
        end
    endfunction

    task automatic check(input string tag, input logic exp_tk, input logic [CW-1:0] exp_c);
        total++;
        if (take_irq !== exp_tk || irq_cause !== exp_c) begin
            bad++;
            $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
                     tag, take_irq, irq_cause, exp_tk, exp_c);
        end
    endtask

    task automatic drive(input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
                         input logic [1:0] pr, input logic mie, input logic sie);
        pend_vec = p; en_vec = e; deleg_vec = d; cur_priv = pr; m_gie = mie; s_gie = sie;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic          etk;
        logic [CW-1:0] ec;

        // R9: reset clears outputs even with a winning input present.
        @(negedge clk);
        drive(16'h0001, 16'h0001, 16'h0000, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R9 reset state", 1'b0, '0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next falling edge.
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].p, TBL[k].e, TBL[k].d, TBL[k].pr, TBL[k].mie, TBL[k].sie);
            @(negedge clk);
            check($sformatf("R%0d table row %0d", TBL[k].req, k), TBL[k].tk, CW'(TBL[k].cause));
        end

        // R9 latency: the output holds the old decision until the next edge.
        drive(16'h0080, 16'h0080, 16'h0000, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        drive(16'h0008, 16'h0008, 16'h0000, 2'd0, 1'b0, 1'b0);
        #1;
        check("R9 before edge", 1'b1, CW'(7));
        @(negedge clk);
        check("R9 after edge", 1'b1, CW'(3));

        // R6: a single source walked across every index.
        for (int i = 0; i < N; i++) begin
            drive(N'(1) << i, N'(1) << i, '0, 2'd0, 1'b0, 1'b0);
            @(negedge clk);
            check("R6 single bit", 1'b1, CW'(i));
        end

        // R7: all-zero vectors at every privilege code.
        for (int q = 0; q < 4; q++) begin
            drive('0, '0, '0, 2'(q), 1'b1, 1'b1);
            @(negedge clk);
            check("R7 all zero", 1'b0, '0);
        end

        // R1 R2 R3 R4 R5 R6 R8: random patterns against the reference model.
        for (int r = 0; r < 400; r++) begin
            logic [N-1:0] p;
            logic [N-1:0] e;
            logic [N-1:0] d;
            logic [1:0]   pr;
            logic         mie;
            logic         sie;
            p = N'($urandom) & N'($urandom);
            e = N'($urandom);
            d = N'($urandom);
            pr = 2'($urandom);
            mie = 1'($urandom);
            sie = 1'($urandom);
            drive(p, e, d, pr, mie, sie);
            ref_model(p, e, d, pr, mie, sie, etk, ec);
            @(negedge clk);
            check("R6 random vs model", etk, ec);
        end

        // R9: reset applied mid-run clears the outputs.
        drive(16'h0004, 16'h0004, 16'h0000, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", 1'b1, CW'(2));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule